// File: doc/BRIEF.md
# ROM Emulator with Sequential Host Loader

This block is a 2048-by-8 memory that takes the place of a read-only memory in a target system. A host loads it and reads it back. One host-driven select line decides who owns the memory. With the line low, the target owns it: the target's 11 address lines pick a location, and the byte appears on the target data bus when the target enables its chip and its output. With the line high, the host owns it. The address then comes from an internal binary counter, so the host has no random access. The host clears the counter and then steps it, writing or reading one byte per strobe.

The storage is split into two 1K banks. The ten low address bits are shared by both banks, and the top bit chooses one bank through complementary chip selects. No bank is selected unless an access is under way. A full image loads with one clear followed by 2048 write strobes that carry the auto-increment request.

Top module: `rom_emu_loader`

## Requirements
- R1: Every one of the 2048 locations holds its own 8-bit value. A byte the host stores at a counter address reads back unchanged at the same target address.
- R2: When `host_sel` is 0, `tgt_addr` addresses the memory. When it is 1, the counter addresses the memory, `tgt_addr` has no effect and `tgt_data_vld` is 0.
- R3: The counter is 0 after reset. While `host_sel` is 1, a `ctr_clr` cycle sets it to 0, and the clear wins over any increment requested in the same cycle.
- R4: While `host_sel` is 1, a `ctr_inc` cycle adds one to the counter, taking effect from the next cycle. The value after 2047 is 0.
- R5: A host write or read cycle with `auto_inc` set accesses the current address and then adds one to the counter. The counter moves by exactly one, even when `ctr_inc` is high in the same cycle.
- R6: A `host_wr` cycle while `host_sel` is 1 stores `host_wdata` at the current counter address on that clock edge.
- R7: `host_rdata` shows the byte at the counter address, without a clock, while `host_sel` and `host_rd` are both 1. At all other times it is 0.
- R8: `tgt_data_vld` is 1 only when `host_sel` is 0 and both `tgt_ce_n` and `tgt_oe_n` are 0. When it is 1, `tgt_data` carries the addressed byte. When it is 0, `tgt_data` is 0, which stands for high impedance.
- R9: While `host_sel` is 0, `host_wr`, `host_rd`, `ctr_inc`, `ctr_clr` and `auto_inc` change neither the memory nor the counter.
- R10: Address bit 10 picks one of two 1K banks, and at most one bank is selected at a time. No bank is selected while nothing is accessing the memory. Addresses that differ only in bit 10 hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the counter |
| host_sel | input | 1 | Ownership: 1 = host, 0 = target |
| ctr_clr | input | 1 | Host counter clear |
| ctr_inc | input | 1 | Host counter step |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| auto_inc | input | 1 | Step the counter after this host access |
| host_wdata | input | 8 | Byte to store |
| host_rdata | output | 8 | Byte at the counter address during a host read |
| tgt_addr | input | 11 | Target address |
| tgt_ce_n | input | 1 | Target chip enable, active low |
| tgt_oe_n | input | 1 | Target output enable, active low |
| tgt_data | output | 8 | Byte toward the target |
| tgt_data_vld | output | 1 | Target bus driven; 0 stands for high impedance |

## Verification
The counter is not visible at the ports. A wrong count therefore shows up only on the next host read or on a later target read, as a byte taken from, or stored to, a neighbouring location. The checks after clear, step, wrap and combined strobes each read a location at once, so an error there appears within one cycle. A stray write made while the target owns the memory, or a bank-select error, corrupts a byte that a later target read reports at the address concerned, for example 0x3FF against 0x400.

// File: rtl/rom_emu_loader.sv
module rom_emu_loader #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              ctr_clr,
  input  logic              ctr_inc,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              auto_inc,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              tgt_ce_n,
  input  logic              tgt_oe_n,
  output logic [DATA_W-1:0] tgt_data,
  output logic              tgt_data_vld
);
  localparam int BANK_AW = ADDR_W - 1;
  localparam int BANK_D  = 1 << BANK_AW;

  logic [ADDR_W-1:0] ctr;
  logic [ADDR_W-1:0] mem_addr;
  logic              host_acc, tgt_acc, step;
  logic [1:0]        bank_cs;
  logic [DATA_W-1:0] bank_q [2];
  logic [DATA_W-1:0] rd_q;

  assign host_acc = host_sel & (host_wr | host_rd);
  assign tgt_acc  = ~host_sel & ~tgt_ce_n;
  assign mem_addr = host_sel ? ctr : tgt_addr;
  assign bank_cs[0] = (host_acc | tgt_acc) & ~mem_addr[ADDR_W-1];
  assign bank_cs[1] = (host_acc | tgt_acc) &  mem_addr[ADDR_W-1];
  assign step = host_sel & (ctr_inc | (auto_inc & (host_wr | host_rd)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctr <= '0;
    else if (host_sel & ctr_clr) ctr <= '0;
    else if (step)              ctr <= ctr + 1'b1;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] cells [BANK_D];
    always_ff @(posedge clk) begin
      if (bank_cs[b] & host_sel & host_wr)
        cells[mem_addr[BANK_AW-1:0]] <= host_wdata;
    end
    assign bank_q[b] = bank_cs[b] ? cells[mem_addr[BANK_AW-1:0]] : '0;
  end

  assign rd_q         = bank_q[0] | bank_q[1];
  assign host_rdata   = (host_sel & host_rd) ? rd_q : '0;
  assign tgt_data_vld = tgt_acc & ~tgt_oe_n;
  assign tgt_data     = tgt_data_vld ? rd_q : '0;
endmodule

module rom_emu_loader_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              ctr_clr,
  input logic              ctr_inc,
  input logic              host_wr,
  input logic              host_rd,
  input logic              auto_inc,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              tgt_ce_n,
  input logic [DATA_W-1:0] tgt_data,
  input logic              tgt_data_vld,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ADDR_W-1:0] ctr,
  input logic [1:0]        bank_cs
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_sel & ctr_clr) |-> ctr == '0); // R3
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_sel & ~ctr_clr & ctr_inc & (ctr == TOP)) |-> ctr == '0); // R4
  AST_CTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_sel & ~ctr_clr & (ctr_inc | (auto_inc & (host_wr | host_rd))))
      |-> ctr == ADDR_W'($past(ctr) + 1'b1)); // R5
  AST_TGT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(~host_sel) |-> $stable(ctr)); // R9
  AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (~host_sel & $past(~host_sel) & tgt_data_vld & $past(tgt_data_vld) & $stable(tgt_addr))
      |-> $stable(tgt_data)); // R9
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs)); // R10
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel ? ~(host_wr | host_rd) : tgt_ce_n) |-> bank_cs == 2'b00); // R10
  AST_TGT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ~tgt_data_vld |-> tgt_data == '0); // R8
  AST_HOST_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> ~tgt_data_vld); // R2
  AST_HOST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ~(host_sel & host_rd) |-> host_rdata == '0); // R7
endmodule

bind rom_emu_loader rom_emu_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .ctr_clr(ctr_clr), .ctr_inc(ctr_inc),
  .host_wr(host_wr), .host_rd(host_rd), .auto_inc(auto_inc), .tgt_addr(tgt_addr),
  .tgt_ce_n(tgt_ce_n), .tgt_data(tgt_data), .tgt_data_vld(tgt_data_vld),
  .host_rdata(host_rdata), .ctr(ctr), .bank_cs(bank_cs)
);

// File: tb/rom_emu_loader_tb.sv
module rom_emu_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, ctr_clr = 1'b0, ctr_inc = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, auto_inc = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [10:0] tgt_addr = '0;
  logic        tgt_ce_n = 1'b1, tgt_oe_n = 1'b1;
  logic [7:0]  tgt_data;
  logic        tgt_data_vld;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom_emu_loader u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .ctr_clr(ctr_clr), .ctr_inc(ctr_inc),
    .host_wr(host_wr), .host_rd(host_rd), .auto_inc(auto_inc), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tgt_addr(tgt_addr), .tgt_ce_n(tgt_ce_n), .tgt_oe_n(tgt_oe_n),
    .tgt_data(tgt_data), .tgt_data_vld(tgt_data_vld)
  );

  // {host_sel, tgt_ce_n, tgt_oe_n, tgt_addr, expected valid}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 11'h000, 1'b1},
    {1'b0, 1'b0, 1'b0, 11'h7FF, 1'b1},
    {1'b0, 1'b1, 1'b0, 11'h010, 1'b0},
    {1'b0, 1'b0, 1'b1, 11'h010, 1'b0},
    {1'b0, 1'b1, 1'b1, 11'h010, 1'b0},
    {1'b1, 1'b0, 1'b0, 11'h010, 1'b0},
    {1'b0, 1'b0, 1'b0, 11'h400, 1'b1},
    {1'b0, 1'b0, 1'b0, 11'h3FF, 1'b1}
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + (a >>> 5) + 11);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic host_cycle(input logic clr, input logic inc, input logic wr,
                            input logic ai, input logic [7:0] d);
    ctr_clr = clr; ctr_inc = inc; host_wr = wr; auto_inc = ai; host_wdata = d;
    @(posedge clk); @(negedge clk);
    ctr_clr = 0; ctr_inc = 0; host_wr = 0; auto_inc = 0;
  endtask

  task automatic host_read(input string r, input logic [7:0] exp, input logic ai, input logic inc);
    host_rd = 1; auto_inc = ai; ctr_inc = inc;
    #1 chk(r, host_rdata, exp);
    @(posedge clk); @(negedge clk);
    host_rd = 0; auto_inc = 0; ctr_inc = 0;
  endtask

  task automatic tgt_read(input string r, input logic [10:0] a, input logic [7:0] exp);
    tgt_addr = a; #1;
    chk(r, {tgt_data_vld, tgt_data}, {1'b1, exp});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary;
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset valid", tgt_data_vld, 0);
    chk("R8 reset data", tgt_data, 0);
    chk("R7 reset host data", host_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R6 R5 R3: load from reset counter value, no clear
    host_sel = 1;
    for (int a = 0; a < 2048; a++) host_cycle(0, 0, 1, 1, pat(a));

    // R1: full target sweep
    host_sel = 0; tgt_ce_n = 0; tgt_oe_n = 0;
    for (int a = 0; a < 2048; a++) tgt_read("R1 target sweep", 11'(a), pat(a));
    tgt_read("R10 bank low top", 11'h3FF, pat(11'h3FF));
    tgt_read("R10 bank high bottom", 11'h400, pat(11'h400));

    // R8 R2: vector table
    for (int i = 0; i < 8; i++) begin
      host_sel = VEC[i][14]; tgt_ce_n = VEC[i][13]; tgt_oe_n = VEC[i][12];
      tgt_addr = VEC[i][11:1];
      #1 chk("R8 R2 gating table", {tgt_data_vld, tgt_data},
             {VEC[i][0], VEC[i][0] ? pat(int'(VEC[i][11:1])) : 8'h00});
      #1;
    end
    @(negedge clk);

    // R7 R2 R5: sequential readback, counter wrapped to 0 after load
    host_sel = 1; tgt_addr = 11'h123;
    for (int a = 0; a < 2048; a++) host_read("R7 R2 host readback", pat(a), 1, 0);
    host_read("R5 auto wrap", pat(0), 0, 0);

    // R4 step, R3 clear priority
    for (int i = 0; i < 5; i++) host_cycle(0, 1, 0, 0, 8'h00);
    host_read("R4 step count", pat(5), 0, 0);
    host_cycle(1, 1, 0, 0, 8'h00);
    host_read("R3 clear over step", pat(0), 0, 0);

    // R9: host strobes ignored while target owns
    for (int i = 0; i < 5; i++) host_cycle(0, 1, 0, 0, 8'h00);
    host_sel = 0; tgt_ce_n = 0; tgt_oe_n = 0;
    host_cycle(0, 1, 1, 1, 8'hAA);
    host_cycle(1, 0, 1, 0, 8'h55);
    host_rd = 1; #1 chk("R7 host read while target owns", host_rdata, 0); host_rd = 0;
    tgt_read("R9 no stray write", 11'd5, pat(5));
    tgt_read("R9 no write at zero", 11'd0, pat(0));
    @(negedge clk);
    host_sel = 1;
    host_read("R9 counter held", pat(5), 0, 0);

    // R5: step and auto access together move by one
    host_read("R5 combined access", pat(5), 1, 1);
    host_read("R5 moved by one", pat(6), 0, 0);

    // R4: wrap by steps
    host_cycle(1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 2047; i++) host_cycle(0, 1, 0, 0, 8'h00);
    host_read("R4 at top", pat(2047), 0, 0);
    host_cycle(0, 1, 0, 0, 8'h00);
    host_read("R4 wrap to zero", pat(0), 0, 0);

    // R10 R6: write into upper bank start, neighbours intact
    host_cycle(1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 1024; i++) host_cycle(0, 1, 0, 0, 8'h00);
    host_cycle(0, 0, 1, 0, 8'hC3);
    host_read("R6 host write", 8'hC3, 0, 0);
    host_sel = 0; tgt_ce_n = 0; tgt_oe_n = 0;
    tgt_read("R10 written upper bank", 11'h400, 8'hC3);
    tgt_read("R10 lower bank alias intact", 11'h000, pat(0));
    tgt_read("R10 lower bank top intact", 11'h3FF, pat(11'h3FF));

    done = 1;
    summary;
    $finish;
  end
endmodule